// File: doc/BRIEF.md
# Bitstream Decimating FIR (80 taps, 16:1)

This block turns the 1-bit stream of an oversampled sigma-delta modulator into multi-bit samples at one sixteenth of the input rate. It applies an 80-tap FIR filter and decimates by 16. Each input bit stands for +1 or -1, so every tap product is the coefficient itself or its negation, and the filter needs no multiplier.

The filter keeps no copy of past input bits. It runs five signed accumulators, one for each group of 16 coefficients. Every accepted bit adds or subtracts one coefficient in each accumulator, which is five operations per input. A pointer walks through the coefficient groups, one entry per accepted bit. At each block of 16 inputs the partial sums move one place toward the output end, and the accumulator at that end produces the result. The coefficients come in as a packed parameter.

Top module: `bitstream_decim_fir`

## Requirements
- R1: On every 16th accepted input since reset, the output equals the sum over j = 0..79 of h[j]*x[n-j], where x[n] is the input just accepted and x[n-j] is the input accepted j inputs earlier. An input bit of 1 counts as +1 and 0 counts as -1.
- R2: Inputs that were not accepted since the last reset count as 0 in that sum. This makes the first four outputs after reset partial (warm-up) results.
- R3: `out_vld` is high for exactly one clock, in the cycle that follows the clock edge that accepted the 16th, 32nd, 48th, ... input since reset. It is low in every other cycle.
- R4: A cycle with `bit_vld` low changes no state. Idle gaps between inputs do not change any output value or its timing in terms of accepted inputs.
- R5: `out_data` holds its value between two `out_vld` pulses.
- R6: The output width is COEF_W + clog2(80) bits. Both +sum|h[j]| and -sum|h[j]| appear at the output without wrapping.
- R7: A synchronous reset drives `out_vld` and `out_data` to 0 and discards all partial sums and the position within the current block. The next block starts with the first input accepted after reset.
- R8: Coefficient h[j] is the signed field COEFS[j*COEF_W +: COEF_W]. Tap j = 0 weights the newest input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Modulator bit: 1 means +1, 0 means -1 |
| bit_vld | input | 1 | Qualifies bit_in for this cycle |
| out_data | output | COEF_W+clog2(80) | Signed filter output |
| out_vld | output | 1 | One-cycle strobe, once per 16 accepted inputs |

## Verification
The hardest case to reach is the largest magnitude an accumulator can hold, because only one alignment of 80 bits against the coefficient signs produces it. The bench builds this case from its own coefficient list. After a reset it sends the sign of h[79] first and the sign of h[0] last, so the 80th input falls exactly on a block boundary. It then repeats the sequence with every sign inverted. It also resets in the middle of a block and inserts random idle gaps, to show that partial sums and the pointer position do not carry over.

// File: rtl/bitstream_decim_fir.sv
module bitstream_decim_fir #(
  parameter int DECIM  = 16,
  parameter int PHASES = 5,
  parameter int COEF_W = 16,
  parameter logic [DECIM*PHASES*COEF_W-1:0] COEFS =
    {(DECIM*PHASES){{2'b01, {(COEF_W-2){1'b0}}}}},
  localparam int ACC_W = COEF_W + $clog2(DECIM*PHASES)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bit_in,
  input  logic                    bit_vld,
  output logic signed [ACC_W-1:0] out_data,
  output logic                    out_vld
);
  localparam int PW = $clog2(DECIM);

  logic [PW-1:0] ptr;
  logic          last;
  logic signed [ACC_W-1:0] acc  [PHASES];
  logic signed [ACC_W-1:0] term [PHASES];

  assign last = (ptr == PW'(DECIM-1));

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (bit_vld) ptr <= last ? '0 : ptr + 1'b1;
  end

  for (genvar k = 0; k < PHASES; k++) begin : g_ph
    logic signed [COEF_W-1:0] cf;
    always_comb begin
      cf = COEFS[(k*DECIM + DECIM - 1 - int'(ptr))*COEF_W +: COEF_W];
      term[k] = bit_in ? ACC_W'(cf) : -ACC_W'(cf);
    end

    if (k == PHASES-1) begin : g_top
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else if (bit_vld) acc[k] <= last ? '0 : acc[k] + term[k];
      end
    end else begin : g_mid
      always_ff @(posedge clk) begin
        if (rst) acc[k] <= '0;
        else if (bit_vld) acc[k] <= last ? acc[k+1] + term[k+1] : acc[k] + term[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= bit_vld && last;
      if (bit_vld && last) out_data <= acc[0] + term[0];
    end
  end

  // R3
  vld_after_block_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ptr == '0);
  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bit_vld && last) |=> $stable(out_data));
  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(ptr) && $stable(acc[0]) && !out_vld);
  // R1
  top_restart_chk: assert property (@(posedge clk) disable iff (rst)
    bit_vld && last |=> acc[PHASES-1] == '0);
endmodule

// File: tb/bitstream_decim_fir_tb.sv
module bitstream_decim_fir_tb;
  localparam int TAPS  = 80;
  localparam int CW    = 16;
  localparam int ACC_W = CW + $clog2(TAPS);

  function automatic int coef_of(int j);
    if (j == 0) return 32767;
    if (j == TAPS-1) return -32768;
    return ((j*7919 + 123) % 65536) - 32768;
  endfunction

  function automatic logic [TAPS*CW-1:0] mk_coefs();
    logic [TAPS*CW-1:0] v;
    for (int j = 0; j < TAPS; j++) v[j*CW +: CW] = CW'(coef_of(j));
    return v;
  endfunction

  localparam logic [TAPS*CW-1:0] TB_COEFS = mk_coefs();

  logic clk = 0, rst = 1, bit_in = 0, bit_vld = 0;
  logic signed [ACC_W-1:0] out_data;
  logic out_vld;

  bitstream_decim_fir #(.DECIM(16), .PHASES(5), .COEF_W(CW), .COEFS(TB_COEFS)) u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .out_data(out_data), .out_vld(out_vld));

  always #4 clk = ~clk;

  int total = 0, bad = 0, accepted = 0;
  int hist[$];
  bit exp_vld = 0;
  longint exp_data = 0;
  string tag = "R7";
  bit done = 0;

  function automatic longint model();
    longint s = 0;
    for (int j = 0; j < TAPS && j < hist.size(); j++) s += longint'(hist[j]) * coef_of(j);
    return s;
  endfunction

  task automatic check_cycle();
    if (rst) begin
      hist.delete(); accepted = 0; exp_vld = 0; exp_data = 0;
    end else if (bit_vld) begin
      hist.push_front(bit_in ? 1 : -1);
      if (hist.size() > TAPS) void'(hist.pop_back());
      accepted++;
      exp_vld = (accepted % 16 == 0);
      if (exp_vld) exp_data = model();
    end else exp_vld = 0;
    total++;
    if (out_vld !== exp_vld) begin
      bad++;
      $display("FAIL %s/R3 out_vld actual=%0d expected=%0d", tag, out_vld, exp_vld);
    end
    total++;
    if (longint'(out_data) != exp_data) begin
      bad++;
      $display("FAIL %s%s out_data actual=%0d expected=%0d", tag,
               exp_vld ? "" : "/R5", out_data, exp_data);
    end
  endtask

  task automatic tick(input logic r, input logic v, input logic b);
    @(negedge clk);
    check_cycle();
    rst = r; bit_vld = v; bit_in = b;
  endtask

  task automatic feed(input int n, input int mode, input bit gaps);
    for (int i = 0; i < n; i++) begin
      if (gaps) while ($urandom % 3 == 0) tick(0, 0, $urandom % 2);
      case (mode)
        0: tick(0, 1, $urandom % 2);
        1: tick(0, 1, 1);
        2: tick(0, 1, 0);
        default: tick(0, 1, i % 2);
      endcase
    end
  endtask

  task automatic extreme(input bit neg);
    for (int i = 0; i < TAPS; i++) begin
      int j = TAPS - 1 - i;
      tick(0, 1, (coef_of(j) >= 0) ^ neg);
    end
  endtask

  initial begin
    tag = "R7"; tick(1, 0, 0); tick(1, 0, 0); tick(0, 0, 0); tick(0, 0, 0);
    tag = "R2"; feed(48, 0, 0);
    tag = "R1"; feed(240, 0, 0);
    tag = "R4"; feed(200, 0, 1);
    tag = "R8"; feed(96, 1, 0); feed(96, 2, 0); feed(64, 3, 0);
    tag = "R7"; tick(0, 0, 0); feed(37, 0, 0); tick(1, 1, 1); tick(1, 0, 0);
    tick(0, 0, 0); feed(100, 0, 0);
    tag = "R6"; tick(1, 0, 0); tick(0, 0, 0); extreme(0); feed(16, 0, 0);
    tick(1, 0, 0); tick(0, 0, 0); extreme(1);
    tag = "R4"; for (int i = 0; i < 6; i++) tick(0, 0, 1);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule